// File: doc/BRIEF.md
# Quadrature Phase-Accumulator Oscillator

This block is a numerically controlled oscillator that produces a sine and a cosine sample pair at a frequency picked by a tuning word. A wide phase register advances by the tuning word on every sample enable and wraps naturally at its width. Only the upper bits of the phase are used to look up the waveform. The lower bits are dropped, and each dropped bit costs about 6 dB of spur-free range. Only the first quarter of a sine period is stored. The other three quarters, and the whole cosine, are rebuilt from it by mirroring the table index and flipping the sign.

To produce a tone at frequency f with sample rate fs, load a tuning word of round(2^PHASE_W · f / fs). The frequency step is fs / 2^PHASE_W. For example, a 16-bit phase at an 855 kHz sample rate gives steps of about 13 Hz. The tuning word may change between any two samples. The next sample then continues from the current phase, so a retune causes no phase jump. The output stream carries a valid flag only. The oscillator is paced by its sample enable, so there is no ready input and no back-pressure: the consumer must take every beat on which valid is high.

Top module: `nco_quad`

## Requirements
- R1: A synchronous, active-high reset clears the phase to zero, drops valid, and sets both sample outputs to zero. The first enabled sample after reset therefore uses phase 0.
- R2: On each cycle with `en_i` high, the phase becomes phase + `tw_i` modulo 2^PHASE_W. On a cycle with `en_i` low, the phase does not change.
- R3: A new tuning word is used from the next enabled sample onward. That sample starts from the accumulated phase, not from zero.
- R4: The lookup address is the top ADDR_W bits of the phase. With `tw_i` = 1, the address, and so the output, changes only once every 2^(PHASE_W-ADDR_W) samples.
- R5: For lookup address a, `sin_o` is within 1 LSB of round(A·sin(2π(a+0.5)/2^ADDR_W)), where A = 2^(OUT_W-1)-1. The output is two's complement.
- R6: For the same address, `cos_o` is within 1 LSB of round(A·cos(2π(a+0.5)/2^ADDR_W)).
- R7: Neither output ever carries the most negative code. All magnitudes stay at or below A.
- R8: If `en_i` is high in cycle c, then `valid_o` is high in cycle c+2 and carries that sample. `valid_o` never rises without a matching enable.
- R9: While `valid_o` is low, `sin_o` and `cos_o` keep their last values.
- R10: With `en_i` held high on consecutive cycles, `valid_o` is high on consecutive cycles, one sample per cycle, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Sample enable; advances the phase and launches one sample |
| tw_i | input | PHASE_W | Tuning word, phase increment per sample |
| valid_o | output | 1 | Sample pair valid (no back-pressure) |
| sin_o | output | OUT_W | Signed sine sample |
| cos_o | output | OUT_W | Signed cosine sample |

## Verification
The bench builds the block with a 16-bit phase, an 8-bit lookup address and 12-bit samples. With these values the quarter table has 64 entries. A step of one address per sample then visits every table entry in all four quadrants of both outputs within a few hundred cycles. The small phase width also brings wraparound, a backward-running tuning word, and the 256-sample dwell of the smallest tuning word into a short run. This lets the bench confirm the resolution rule and the seamless retune against a floating-point reference.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    QD_RISE = 2'd0,
    QD_FALL = 2'd1,
    QD_NEG_FALL = 2'd2,
    QD_NEG_RISE = 2'd3
  } quad_e;

  localparam real TWO_PI = 6.283185307179586;

  // Round half away from zero.
  function automatic int round_real(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tw_i,
  output logic [PHASE_W-1:0] phase_o
);

  logic [PHASE_W-1:0] acc_q;

  // Wraps naturally at 2^PHASE_W.
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (en_i) acc_q <= acc_q + tw_i;
  end

  assign phase_o = acc_q;

endmodule

// File: rtl/nco_fold.sv
module nco_fold
  import nco_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFFSET = 0,
  localparam int QAW = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [QAW-1:0]    idx_o,
  output logic              neg_o
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFFSET);

  logic [ADDR_W-1:0] rot;
  quad_e             quad;

  always_comb begin
    rot  = addr_i + OFS;
    quad = quad_e'(rot[ADDR_W-1 -: 2]);
    // Mirror k -> (2^QAW - 1 - k) in the descending quadrants.
    if (quad == QD_FALL || quad == QD_NEG_RISE) idx_o = ~rot[QAW-1:0];
    else idx_o = rot[QAW-1:0];
    neg_o = (quad == QD_NEG_FALL) || (quad == QD_NEG_RISE);
  end

endmodule

// File: rtl/nco_qrom.sv
module nco_qrom
  import nco_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OUT_W = 16,
  localparam int QAW = ADDR_W - 2,
  localparam int QDEPTH = 1 << QAW,
  localparam int MAG_W = OUT_W - 1
) (
  input  logic [QAW-1:0]   idx_i,
  output logic [MAG_W-1:0] mag_o
);

  localparam real AMP = real'((1 << (OUT_W - 1)) - 1);

  // Sample at half-step offsets so the mirrored index is exactly symmetric.
  function automatic int quarter_val(input int k);
    real ang;
    ang = TWO_PI * (real'(k) + 0.5) / real'(1 << ADDR_W);
    return round_real(AMP * $sin(ang));
  endfunction

  logic [MAG_W-1:0] tbl [QDEPTH];

  for (genvar k = 0; k < QDEPTH; k++) begin : g_tbl
    localparam int VAL = quarter_val(k);
    assign tbl[k] = MAG_W'(VAL);
  end

  assign mag_o = tbl[idx_i];

endmodule

// File: rtl/nco_quad.sv
module nco_quad
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W = 10,
  parameter int OUT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tw_i,
  output logic               valid_o,
  output logic [OUT_W-1:0]   sin_o,
  output logic [OUT_W-1:0]   cos_o
);

  localparam int QAW = ADDR_W - 2;
  localparam int QDEPTH = 1 << QAW;
  localparam int MAG_W = OUT_W - 1;
  localparam int NCH = 2;   // channel 0 sine, channel 1 cosine

  logic [PHASE_W-1:0] phase_q;
  logic [ADDR_W-1:0]  addr;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .tw_i   (tw_i),
    .phase_o(phase_q)
  );

  assign addr = phase_q[PHASE_W-1 -: ADDR_W];

  logic [QAW-1:0]   idx_c [NCH];
  logic             neg_c [NCH];
  logic [QAW-1:0]   idx_q [NCH];
  logic             neg_q [NCH];
  logic [MAG_W-1:0] mag_c [NCH];
  logic             v1_q;
  logic [OUT_W-1:0] smp_q [NCH];
  logic             v2_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // Cosine leads sine by one quarter of the address range.
    nco_fold #(.ADDR_W(ADDR_W), .OFFSET(ch * QDEPTH)) u_fold (
      .addr_i(addr),
      .idx_o (idx_c[ch]),
      .neg_o (neg_c[ch])
    );
    nco_qrom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
      .idx_i(idx_q[ch]),
      .mag_o(mag_c[ch])
    );
  end

  // Stage 1: fold the current phase; stage 2: look up and apply sign.
  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      for (int ch = 0; ch < NCH; ch++) begin
        idx_q[ch] <= '0;
        neg_q[ch] <= 1'b0;
        smp_q[ch] <= '0;
      end
    end else begin
      v1_q <= en_i;
      v2_q <= v1_q;
      for (int ch = 0; ch < NCH; ch++) begin
        if (en_i) begin
          idx_q[ch] <= idx_c[ch];
          neg_q[ch] <= neg_c[ch];
        end
        if (v1_q) begin
          if (neg_q[ch]) smp_q[ch] <= -{1'b0, mag_c[ch]};
          else smp_q[ch] <= {1'b0, mag_c[ch]};
        end
      end
    end
  end

  assign valid_o = v2_q;
  assign sin_o   = smp_q[0];
  assign cos_o   = smp_q[1];

endmodule

// File: rtl/nco_quad_chk.sv
module nco_quad_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               en_i,
  input logic [PHASE_W-1:0] tw_i,
  input logic [PHASE_W-1:0] phase_q,
  input logic               valid_o,
  input logic [OUT_W-1:0]   sin_o,
  input logic [OUT_W-1:0]   cos_o
);

  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W - 1){1'b0}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2: enabled cycle advances the phase by the tuning word
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    en_i |=> phase_q == PHASE_W'($past(phase_q) + $past(tw_i)));

  // R2: idle cycle leaves the phase alone
  a_r2_phase_idle: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(phase_q));

  // R8: valid follows enable by two cycles
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> valid_o == $past(en_i, 2));

  // R7: most negative code never emitted
  a_r7_no_most_neg: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (sin_o != MOST_NEG) && (cos_o != MOST_NEG));

  // R9: samples hold while valid is low
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1) && !valid_o |-> $stable(sin_o) && $stable(cos_o));

endmodule

bind nco_quad nco_quad_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_i   (en_i),
  .tw_i   (tw_i),
  .phase_q(phase_q),
  .valid_o(valid_o),
  .sin_o  (sin_o),
  .cos_o  (cos_o)
);

// File: tb/nco_quad_tb.sv
`timescale 1ns/100ps
module nco_quad_tb;

  localparam int PW = 16;
  localparam int AW = 8;
  localparam int OW = 12;
  localparam real AMP = 2047.0;
  localparam real TPI = 6.283185307179586;
  localparam int NVEC = 8;

  // tuning word, enabled samples, gap (idle cycle after each sample)
  localparam int unsigned V_TW  [NVEC] = '{256, 1, 16384, 65280, 12345, 20000, 0, 32768};
  localparam int unsigned V_N   [NVEC] = '{260, 300, 12, 40, 100, 60, 10, 8};
  localparam int unsigned V_GAP [NVEC] = '{0, 0, 0, 0, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [PW-1:0] tw = '0;
  logic valid;
  logic [OW-1:0] sin_s, cos_s;

  always #2.5 clk = ~clk;

  nco_quad #(.PHASE_W(PW), .ADDR_W(AW), .OUT_W(OW)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .tw_i(tw),
    .valid_o(valid), .sin_o(sin_s), .cos_o(cos_s)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [PW-1:0] acc_m = '0;
  logic [PW-1:0] cur_tw = '0;
  bit prev_v = 1'b0;
  logic [PW-1:0] prev_ph = '0;
  logic [OW-1:0] last_s = '0, last_c = '0;

  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit e, input string tag);
    bit cv;
    logic [PW-1:0] cph;
    int a, es, ec, gs, gc;
    en = e;
    tw = cur_tw;
    cv = e;
    cph = acc_m;
    if (e) acc_m = acc_m + cur_tw;
    @(negedge clk);
    gs = int'($signed(sin_s));
    gc = int'($signed(cos_s));
    if (prev_v) begin
      a  = int'(prev_ph >> (PW - AW));
      es = rnd(AMP * $sin(TPI * (real'(a) + 0.5) / 256.0));
      ec = rnd(AMP * $cos(TPI * (real'(a) + 0.5) / 256.0));
      check(valid === 1'b1, tag, "R8/R10 valid after enable", int'(valid), 1);
      check((gs - es) <= 1 && (es - gs) <= 1, tag, "R5 sine", gs, es);
      check((gc - ec) <= 1 && (ec - gc) <= 1, tag, "R6 cosine", gc, ec);
    end else begin
      check(valid === 1'b0, tag, "R8 no valid without enable", int'(valid), 0);
      check(sin_s === last_s && cos_s === last_c, tag, "R9 hold",
            gs, int'($signed(last_s)));
    end
    last_s = sin_s;
    last_c = cos_s;
    prev_v = cv;
    prev_ph = cph;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    acc_m = '0;
    prev_v = 1'b0;
    check(valid === 1'b0, "R1", "valid after reset", int'(valid), 0);
    check(sin_s === '0 && cos_s === '0, "R1", "samples after reset",
          int'($signed(sin_s)), 0);
    last_s = sin_s;
    last_c = cos_s;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R8: single enable gives exactly one valid two cycles later; R1 phase 0
    cur_tw = 16'd5000;
    tick(1'b1, "R8");
    tick(1'b0, "R1");
    tick(1'b0, "R8");
    tick(1'b0, "R9");

    // Vector walk; phase carries over between entries (R3 continuity)
    for (int v = 0; v < NVEC; v++) begin
      cur_tw = PW'(V_TW[v]);
      for (int i = 0; i < int'(V_N[v]); i++) begin
        case (v)
          0: tick(1'b1, "R10");
          1: tick(1'b1, "R4");
          2: tick(1'b1, "R7");
          3: tick(1'b1, "R2");
          4: tick(1'b1, "R9");
          5: tick(1'b1, "R3");
          default: tick(1'b1, "R2");
        endcase
        if (V_GAP[v] != 0) tick(1'b0, "R9");
      end
    end
    tick(1'b0, "R8");
    tick(1'b0, "R9");

    // R1: reset mid-run restarts at phase 0
    do_reset();
    cur_tw = 16'd777;
    tick(1'b1, "R1");
    tick(1'b0, "R1");
    check(int'($signed(sin_s)) == 25, "R1", "first sine after reset",
          int'($signed(sin_s)), 25);
    check(int'($signed(cos_s)) >= 2045, "R1", "first cosine after reset",
          int'($signed(cos_s)), 2047);

    // R4: tw=1 holds the address for 256 samples, then steps once
    do_reset();
    cur_tw = 16'd1;
    for (int i = 0; i < 256; i++) tick(1'b1, "R4");
    tick(1'b1, "R4");
    check(int'($signed(sin_s)) == 25, "R4", "sine before address step",
          int'($signed(sin_s)), 25);
    tick(1'b0, "R4");
    check(int'($signed(sin_s)) == 75, "R4", "sine after address step",
          int'($signed(sin_s)), 75);

    summary();
  end

endmodule